// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block watches over software by means of a 7-bit down-counter that decrements on a slow tick taken from the peripheral clock through a selectable divider. Software must reload the counter before it falls out of its upper half, and it may only do so once the counter has dropped to or below a programmed window limit. A reload that comes too soon, a counter that drops below 0x40, or a deliberate write that clears the top counter bit, each produce a one-cycle system reset request.

Supervision is off after reset and is switched on by a control write; from then on only a hardware reset turns it off. The counter decrements whether or not supervision is on. An optional early-warning flag is raised one count before timeout, so that an interrupt routine can still reload the counter in time. The surrounding bus wrapper turns register accesses into the write strobes below; the reset request goes to the chip's reset logic.

Top module: `win_watchdog`

## Requirements
- R1: After `rst_n` is low, `count_o` is 0x7F, `armed_o`, `warn_irq_o` and `rst_req_o` are 0, the window limit is 0x7F, the divider select is 0 and the early-warning enable is 0.
- R2: On every tick that is not overridden by a control write, the counter drops by one, whether or not supervision is on; 0x00 wraps to 0x7F.
- R3: A free-running cycle counter starts at 0 on the first rising edge after reset release and increments on every edge; a tick occurs on each edge at which its low BASE_LOG+sel bits are all ones, giving one tick every 2^(BASE_LOG+sel) cycles (sel in 0..3).
- R4: A control write (`ctl_wdata[7]` = enable, `ctl_wdata[6:0]` = counter value) loads the counter on the edge where it is sampled, taking precedence over a tick on that edge. Writing bit 7 as 1 sets `armed_o`; writing it as 0 leaves `armed_o` unchanged.
- R5: When supervision is on and a tick moves the counter from 0x40 to 0x3F, a reset is requested.
- R6: A control write that leaves supervision on requests a reset when the counter value just before the write is greater than the window limit; with the counter at or below the limit and bit 6 of the written value set, no reset is requested.
- R7: A control write that leaves supervision on with bit 6 of the written value 0 requests a reset at once.
- R8: `rst_req_o` is high for exactly one cycle, starting right after the edge at which the request condition is sampled; after the first request no further request is made until `rst_n` is asserted.
- R9: When the early-warning enable is set and a tick moves the counter from 0x41 to 0x40, `warn_irq_o` becomes 1. A flag write with `flag_wdata` = 0 clears it, a flag write with 1 has no effect, and a set on the same edge wins over a clear.
- R10: A configuration write sets the window limit from `cfg_wdata[6:0]`, the divider select from `cfg_wdata[8:7]` and the early-warning enable from `cfg_wdata[9]`, all taking effect from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the chip reset logic |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: bit 7 enable, bits 6:0 counter value |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 10 | Configuration: bit 9 early-warning enable, bits 8:7 divider select, bits 6:0 window limit |
| flag_wr | input | 1 | Early-warning flag write strobe |
| flag_wdata | input | 1 | Value written to the flag (0 clears, 1 ignored) |
| count_o | output | 7 | Current counter value |
| armed_o | output | 1 | Supervision is on |
| warn_irq_o | output | 1 | Early-warning flag / interrupt |
| rst_req_o | output | 1 | One-cycle registered reset request |

## Verification
Every result of a write or tick is registered, so the counter, enable, flag and reset request all change at the same rising edge that samples the cause and are due one cycle after the inputs are driven. The bench drives inputs on the falling edge and compares all four outputs on the next falling edge against a cycle model that follows the requirements, including its own edge count since reset to place ticks. Directed cases pin the first tick to the fourth edge after reset, the early-warning flag to the cycle the counter shows 0x40, and the reset pulse to the single cycle after the cause.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 7;
  localparam int SEL_W = 2;
  localparam int CTL_W = CNT_W + 1;
  localparam int CFG_W = CNT_W + SEL_W + 1;

  localparam logic [CNT_W-1:0] CNT_RST  = 7'h7F;
  localparam logic [CNT_W-1:0] WIN_RST  = 7'h7F;
  localparam logic [CNT_W-1:0] LAST_OK  = 7'h40;
  localparam logic [CNT_W-1:0] PRE_WARN = 7'h41;

  // control word layout: enable on top, counter below
  typedef struct packed {
    logic             arm;
    logic [CNT_W-1:0] cnt;
  } ctl_t;

  // configuration word layout: warn enable, divider select, window limit
  typedef struct packed {
    logic             warn_en;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int BASE_LOG = 12,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);
  localparam int MAX_SH = (1 << SEL_W) - 1;
  localparam int PRE_W  = BASE_LOG + MAX_SH;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  // per-bit mask: bit i takes part when i < BASE_LOG + sel
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = ((BASE_LOG + int'(sel)) > i);
  end

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = &(pre_q | ~mask);

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dec_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign dec_o  = tick & ~load;
  assign cnt_en = load | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (tick)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_RST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt_q == CNT_W'($past(cnt_q) - 7'd1));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_trip.sv
module wdg_trip
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             ctl_wr,
  input  ctl_t             ctl_val,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] win,
  input  logic             dec,
  input  logic             warn_en,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             rst_req_o,
  output logic             flag_o
);
  logic arm_after;
  logic hit_under, hit_early, hit_soft, hit_any;
  logic req_q, req_d;
  logic done_q, done_d;
  logic flag_q, flag_d;
  logic flag_set, flag_clr;

  always_comb begin
    arm_after = armed | (ctl_wr & ctl_val.arm);
    hit_under = armed & dec & (cnt == LAST_OK);
    hit_early = ctl_wr & arm_after & (cnt > win);
    hit_soft  = ctl_wr & arm_after & ~ctl_val.cnt[CNT_W-1];
    hit_any   = hit_under | hit_early | hit_soft;
    req_d     = hit_any & ~done_q;
    done_d    = done_q | hit_any;
  end

  always_comb begin
    flag_set = warn_en & dec & (cnt == PRE_WARN);
    flag_clr = flag_wr & ~flag_wdata;
    flag_d   = flag_set | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      done_q <= done_d;
      flag_q <= flag_d;
    end
  end

  assign rst_req_o = req_q;
  assign flag_o    = flag_q;

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R8
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !req_q);

  // R5
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dec && cnt == LAST_OK && !done_q) |=> req_q);

  // R6
  early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && armed && cnt > win && !done_q) |=> req_q);

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cnt == LAST_OK);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int BASE_LOG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o,
  output logic             warn_irq_o,
  output logic             rst_req_o
);
  ctl_t             ctl_val;
  cfg_t             cfg_q, cfg_d;
  logic             armed_q, armed_d;
  logic             tick;
  logic             dec;
  logic [CNT_W-1:0] cnt;

  assign ctl_val = ctl_t'(ctl_wdata);

  always_comb begin
    cfg_d   = cfg_wr ? cfg_t'(cfg_wdata) : cfg_q;
    armed_d = armed_q | (ctl_wr & ctl_val.arm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{warn_en: 1'b0, sel: '0, win: WIN_RST};
      armed_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      armed_q <= armed_d;
    end
  end

  wdg_prescale #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (cfg_q.sel),
    .tick_o (tick)
  );

  wdg_downcount u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (ctl_wr),
    .load_val (ctl_val.cnt),
    .cnt_o    (cnt),
    .dec_o    (dec)
  );

  wdg_trip u_trip (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (armed_q),
    .ctl_wr     (ctl_wr),
    .ctl_val    (ctl_val),
    .cnt        (cnt),
    .win        (cfg_q.win),
    .dec        (dec),
    .warn_en    (cfg_q.warn_en),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .rst_req_o  (rst_req_o),
    .flag_o     (warn_irq_o)
  );

  assign count_o = cnt;
  assign armed_o = armed_q;

  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  // R5
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !ctl_wr) |=> !rst_req_o);
endmodule

// File: tb/sim_win_watchdog.sv
module sim_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int BL         = 2;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       cfg_wr = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic       flag_wr = 1'b0;
  logic       flag_wdata = 1'b0;
  logic [6:0] count_o;
  logic       armed_o, warn_irq_o, rst_req_o;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  // reference state
  logic [6:0] m_cnt, m_win;
  logic [1:0] m_sel;
  logic       m_ewi, m_flag, m_arm, m_trip, m_req;
  int         m_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog #(.BASE_LOG(BL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .count_o(count_o), .armed_o(armed_o),
    .warn_irq_o(warn_irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic tick_due(int n, logic [1:0] sel);
    int mask;
    mask = (1 << (BL + int'(sel))) - 1;
    return (n & mask) == mask;
  endfunction

  // reference model, one step per rising edge
  always @(posedge clk) begin
    logic tk, dec, arm_after, trig, fset, fclr;
    if (!rst_n) begin
      m_cnt = 7'h7F; m_win = 7'h7F; m_sel = 2'd0; m_ewi = 1'b0;
      m_flag = 1'b0; m_arm = 1'b0; m_trip = 1'b0; m_req = 1'b0; m_n = 0;
    end else begin
      tk        = tick_due(m_n, m_sel);
      dec       = tk && !ctl_wr;
      arm_after = m_arm || (ctl_wr && ctl_wdata[7]);
      trig      = (m_arm && dec && m_cnt == 7'h40) ||
                  (ctl_wr && arm_after && ((m_cnt > m_win) || !ctl_wdata[6]));
      m_req     = trig && !m_trip;
      m_trip    = m_trip || trig;
      fset      = m_ewi && dec && m_cnt == 7'h41;
      fclr      = flag_wr && !flag_wdata;
      m_flag    = fset || (m_flag && !fclr);
      if (ctl_wr)   m_cnt = ctl_wdata[6:0];
      else if (dec) m_cnt = m_cnt - 7'd1;
      m_arm = arm_after;
      if (cfg_wr) {m_ewi, m_sel, m_win} = cfg_wdata;
      m_n = m_n + 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all;
    check("R2,R3,R10 count", int'(count_o), int'(m_cnt));
    check("R4 armed", int'(armed_o), int'(m_arm));
    check("R9 warn flag", int'(warn_irq_o), int'(m_flag));
    check("R5,R6,R7,R8 reset request", int'(rst_req_o), int'(m_req));
  endtask

  // one clock: inputs already set; compare after the edge, then idle the strobes
  task automatic step;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
    ctl_wr = 1'b0; cfg_wr = 1'b0; flag_wr = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; step();
  endtask

  task automatic wr_cfg(logic [9:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; step();
  endtask

  task automatic wr_flag(logic v);
    flag_wr = 1'b1; flag_wdata = v; step();
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    ctl_wr = 1'b0; cfg_wr = 1'b0; flag_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  int pulses;

  initial begin
    void'($urandom(32'h5EED_0042));

    // reset state
    do_reset();
    check("R1 count after reset", int'(count_o), 'h7F);
    check("R1 armed after reset", int'(armed_o), 0);
    check("R1 flag after reset", int'(warn_irq_o), 0);
    check("R1 request after reset", int'(rst_req_o), 0);

    // first tick on the fourth edge (sel 0, period 4)
    run(3);
    check("R3 no tick before edge 3", int'(count_o), 'h7F);
    run(1);
    check("R3 first tick", int'(count_o), 'h7E);

    // disarmed counter runs through 0x3F and wraps without a request
    pulses = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (rst_req_o) pulses++;
    end
    check("R2 no request while disarmed", pulses, 0);

    // divider select 3: period 32
    do_reset();
    wr_cfg({1'b0, 2'd3, 7'h7F});
    run(30);
    check("R10 slow tick not yet", int'(count_o), 'h7F);
    run(1);
    check("R10 slow tick at edge 31", int'(count_o), 'h7E);

    // software reset
    do_reset();
    wr_ctl(8'hBF);
    check("R7 software reset pulse", int'(rst_req_o), 1);
    step();
    check("R8 pulse one cycle", int'(rst_req_o), 0);

    // early refresh
    do_reset();
    wr_ctl(8'hFF);
    check("R6 arming at window 0x7F no request", int'(rst_req_o), 0);
    wr_cfg({1'b0, 2'd0, 7'h50});
    wr_ctl(8'hFF);
    check("R6 early refresh request", int'(rst_req_o), 1);
    wr_ctl(8'hBF);
    check("R8 no second request", int'(rst_req_o), 0);

    // enable bit cannot be cleared by software
    do_reset();
    wr_ctl(8'hFF);
    wr_ctl(8'h7F);
    check("R4 enable stays on", int'(armed_o), 1);
    check("R4 counter loaded", int'(count_o), 'h7F);

    // in-window refresh, early warning, timeout
    do_reset();
    wr_ctl(8'hFF);
    wr_cfg({1'b1, 2'd0, 7'h70});
    run(70);
    wr_ctl(8'hFF);
    check("R6 in-window refresh no request", int'(rst_req_o), 0);
    while (!warn_irq_o && cycles < WD_LIMIT) step();
    check("R9 flag with counter at 0x40", int'(count_o), 'h40);
    wr_flag(1'b1);
    check("R9 writing 1 keeps flag", int'(warn_irq_o), 1);
    wr_flag(1'b0);
    check("R9 writing 0 clears flag", int'(warn_irq_o), 0);
    while (!rst_req_o && cycles < WD_LIMIT) step();
    check("R5 timeout at 0x3F", int'(count_o), 'h3F);
    pulses = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (rst_req_o) pulses++;
    end
    check("R8 no later requests", pulses, 0);

    // random episodes
    for (int ep = 0; ep < 24; ep++) begin
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        if ($urandom_range(0, 39) == 0) begin
          ctl_wr = 1'b1;
          ctl_wdata = ($urandom_range(0, 9) < 8) ? {1'b1, 1'b1, 6'($urandom)} : 8'($urandom);
        end
        if ($urandom_range(0, 199) == 0) begin
          cfg_wr = 1'b1;
          cfg_wdata = {1'($urandom), 2'($urandom), 1'b1, 6'($urandom)};
        end
        if ($urandom_range(0, 29) == 0) begin
          flag_wr = 1'b1;
          flag_wdata = 1'($urandom);
        end
        step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  // watchdog
  initial begin
    repeat (WD_LIMIT + 10000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", WD_LIMIT + 10000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule